// File: doc/BRIEF.md
# Bus Grant Arbitration Controller

This block sits on the host side of a shared processor bus and hands the bus to an external master through a three-wire exchange: a wire-ORed request line, a grant line and an acknowledge line. All three are active-low. Request and acknowledge arrive without any timing relation to the local clock, so each passes through a multi-stage synchronizer before the controller acts on it.

The controller watches two status signals from the internal bus engine. One reports that the current operand transfer has finished. The other reports that a locked read-modify-write sequence is in progress. Grant is only offered at a transfer boundary and never while the lock is held. While the processor is halted, either by the external halt input or after a double bus fault, no transfer is running, so the halt indication counts as a boundary. Once the new master acknowledges, grant drops after a fixed delay. If a request is still pending at that point, grant is offered again after a second fixed delay, so that external logic can choose the next master while the current one still owns the bus. The `bus_yield` output tells the internal bus engine not to start a new cycle. It clears only when acknowledge and request are both gone.

Top module: `busgrant_arbiter`

## Requirements
- R1: During and after synchronous reset, `grant_n` is 1 and `bus_yield` is 0.
- R2: While the controller is idle (`bus_yield` was 0), `grant_n` goes to 0 at rising edge P exactly when `req_n` was 0 at edge P-SYNC_STAGES and, at edge P, `(op_end | halted) & ~rmw_lock` is 1. Otherwise `grant_n` stays 1.
- R3: A pending request is not granted while `rmw_lock` is 1. Grant is given at the first edge where the lock is 0 and a boundary is reported.
- R4: When `halted` is 1, grant is given without `op_end`.
- R5: Suppose grant is asserted, and `ack_n` is sampled 0 at edge k after being 1 at edge k-1. Then `grant_n` returns to 1 at edge k+SYNC_STAGES+NEG_DLY.
- R6: Suppose grant is negated after an acknowledge and `req_n` is still 0. Then `grant_n` goes to 0 again REGRANT_DLY edges after the negation.
- R7: A re-issued grant is not negated by an acknowledge the previous master still holds. It negates, with R5 timing, only after `ack_n` goes 1 and then 0 again.
- R8: Suppose grant is asserted with no acknowledge, and `req_n` is first sampled 1 at edge k. Then `grant_n` returns to 1 and `bus_yield` returns to 0 at edge k+SYNC_STAGES.
- R9: `bus_yield` is 1 whenever `grant_n` is 0. It stays 1 while the external master holds acknowledge. After the re-grant window it falls at edge k+SYNC_STAGES, where k is the first edge at which both `ack_n` and `req_n` are sampled 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_n | input | 1 | Wire-ORed bus request from external masters, asynchronous, active low |
| ack_n | input | 1 | Grant acknowledge from the owning master, asynchronous, active low |
| op_end | input | 1 | Internal engine is at an operand transfer boundary |
| rmw_lock | input | 1 | Locked read-modify-write sequence in progress |
| halted | input | 1 | Processor halted (external halt or double fault) |
| grant_n | output | 1 | Bus grant, active low |
| bus_yield | output | 1 | Internal engine must not start a new bus cycle |

## Verification
The embedded assertions check on every cycle that grant never implies a running internal master, that a grant is only raised with a pending synchronized request, that an idle controller offers nothing outside a safe boundary or under the lock, and that the yield flag only clears once request and acknowledge are both gone. The exact latencies can only be shown by the bench's timed scenarios: synchronizer depth, the negation delay after acknowledge, the re-grant gap, and the withdrawal of an unanswered grant. The same holds for the refusal to drop a re-issued grant while the previous master still holds acknowledge. Randomized traffic from an acknowledging agent additionally checks the idle-to-grant decision cycle by cycle against a bench function.

// File: rtl/arb_pkg.sv
// Shared types for the bus grant arbitration controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package arb_pkg;

    // Controller states: idle, grant offered, grant held after acknowledge,
    // bus yielded to the external master.
    typedef enum logic [1:0] {
        ARB_IDLE     = 2'd0,
        ARB_OFFER    = 2'd1,
        ARB_HANDOFF  = 2'd2,
        ARB_YIELDED  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/arb_sync.sv
// Multi-stage synchronizer for one asynchronous active-low input.
// Produces an active-high level. Reset loads the inactive value.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse.
module arb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic level
);

    logic [STAGES-1:0] chain_q;

    // Stage 0 captures the pin value.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= async_n;
    end

    // Each further stage re-times the previous one.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign level = ~chain_q[STAGES-1];

endmodule

// File: rtl/arb_gate.sv
// Decides whether the internal bus is at a point where ownership may move.
// A halted processor runs no transfer, so halt counts as a boundary.
// Assumes: op_end, rmw_lock and halted are synchronous to clk.
module arb_gate (
    input  logic op_end,
    input  logic rmw_lock,
    input  logic halted,
    output logic safe_pt
);

    // Boundary reached and no locked sequence open.
    always_comb begin
        safe_pt = (op_end | halted) & ~rmw_lock;
    end

endmodule

// File: rtl/arb_fsm.sv
// Grant sequencing state machine working on synchronized, active-high levels.
// Offers grant at safe points, holds it NEG_DLY cycles after an acknowledge
// edge, and re-offers it REGRANT_DLY cycles after negation while a request
// is still pending. The outputs are registered.
// Assumes: NEG_DLY >= 1 and REGRANT_DLY >= 1.
module arb_fsm
    import arb_pkg::*;
#(
    parameter int NEG_DLY     = 2,
    parameter int REGRANT_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ack_s,
    input  logic safe_pt,
    output logic grant_q,
    output logic yield_q
);

    localparam int MAXD = (NEG_DLY > REGRANT_DLY) ? NEG_DLY : REGRANT_DLY;
    localparam int CW   = (MAXD < 2) ? 1 : $clog2(MAXD);
    localparam logic [CW-1:0] NEG_LOAD = CW'(NEG_DLY - 1);
    localparam logic [CW-1:0] REG_LOAD = CW'(REGRANT_DLY - 1);

    arb_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ack_d1_q;
    logic          ack_rise;

    assign ack_rise = ack_s & ~ack_d1_q;

    // Remember the previous acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_d1_q <= 1'b0;
        else        ack_d1_q <= ack_s;
    end

    // Next-state and delay-counter logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ARB_IDLE: begin
                if (req_s && safe_pt) st_d = ARB_OFFER;
            end
            ARB_OFFER: begin
                if (ack_rise) begin
                    st_d  = ARB_HANDOFF;
                    cnt_d = NEG_LOAD;
                end else if (!req_s) begin
                    if (ack_s) begin
                        st_d  = ARB_YIELDED;
                        cnt_d = REG_LOAD;
                    end else begin
                        st_d = ARB_IDLE;
                    end
                end
            end
            ARB_HANDOFF: begin
                if (cnt_q == '0) begin
                    st_d  = ARB_YIELDED;
                    cnt_d = REG_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ARB_YIELDED: begin
                if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
                else if (req_s)   st_d  = ARB_OFFER;
                else if (!ack_s)  st_d  = ARB_IDLE;
            end
            default: st_d = ARB_IDLE;
        endcase
    end

    // State, counter and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ARB_IDLE;
            cnt_q   <= '0;
            grant_q <= 1'b0;
            yield_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            grant_q <= (st_d == ARB_OFFER) || (st_d == ARB_HANDOFF);
            yield_q <= (st_d != ARB_IDLE);
        end
    end

    // An idle controller offers nothing outside a safe point.
    assert_idle_waits_safe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ARB_IDLE && !safe_pt) |=> !grant_q);

    // Grant only rises on a pending synchronized request (R2, R6).
    assert_grant_has_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_q) |-> $past(req_s));

    // Grant always comes with the internal engine held off.
    assert_grant_implies_yield_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> yield_q);

    // The internal engine resumes only once request and acknowledge are gone.
    assert_resume_when_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(yield_q) |-> (!$past(ack_s) && !$past(req_s)));

endmodule

// File: rtl/busgrant_arbiter.sv
// Top of the bus grant arbitration controller.
// Synchronizes the external request and acknowledge lines, qualifies
// ownership changes against the internal transfer status, and drives the
// active-low grant and the yield flag for the internal bus engine.
// Assumes: req_n and ack_n are asynchronous; the other inputs are synchronous.
module busgrant_arbiter #(
    parameter int SYNC_STAGES = 2,
    parameter int NEG_DLY     = 2,
    parameter int REGRANT_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic ack_n,
    input  logic op_end,
    input  logic rmw_lock,
    input  logic halted,
    output logic grant_n,
    output logic bus_yield
);

    logic req_s;
    logic ack_s;
    logic safe_pt;
    logic grant_q;
    logic yield_q;

    arb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (req_n),
        .level   (req_s)
    );

    arb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (ack_n),
        .level   (ack_s)
    );

    arb_gate u_gate (
        .op_end   (op_end),
        .rmw_lock (rmw_lock),
        .halted   (halted),
        .safe_pt  (safe_pt)
    );

    arb_fsm #(
        .NEG_DLY     (NEG_DLY),
        .REGRANT_DLY (REGRANT_DLY)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_s   (req_s),
        .ack_s   (ack_s),
        .safe_pt (safe_pt),
        .grant_q (grant_q),
        .yield_q (yield_q)
    );

    assign grant_n   = ~grant_q;
    assign bus_yield = yield_q;

    // A locked read-modify-write keeps an idle controller from granting.
    assert_lock_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_n && !bus_yield && rmw_lock) |=> grant_n);

endmodule

// File: tb/test_busgrant_arbiter.sv
// Self-checking bench: directed timing scenarios followed by random traffic
// from an acknowledging agent. Inputs change on falling edges; outputs are
// sampled on falling edges.
module test_busgrant_arbiter;

    localparam int SYNC = 2;
    localparam int NEG  = 2;
    localparam int REG  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1, ack_n = 1'b1;
    logic op_end = 1'b1, rmw_lock = 1'b0, halted = 1'b0;
    logic grant_n, bus_yield;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    busgrant_arbiter #(.SYNC_STAGES(SYNC), .NEG_DLY(NEG), .REGRANT_DLY(REG)) i_busgrant_arbiter (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .ack_n(ack_n),
        .op_end(op_end), .rmw_lock(rmw_lock), .halted(halted),
        .grant_n(grant_n), .bus_yield(bus_yield)
    );

    // Expected idle-to-grant decision (R2, R3, R4).
    function automatic logic exp_offer(logic old_req_n, logic oe, logic hl, logic lk);
        return !old_req_n && (oe || hl) && !lk;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic to_idle();
        req_n = 1'b1; ack_n = 1'b1; halted = 1'b0; rmw_lock = 1'b0; op_end = 1'b1;
        step(8);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic rq0, rq1, rq2, oe_c, hl_c, lk_c, yprev;
        int phase, dly, hold, sd;
        sd = $urandom(32'd2024);

        step(4);
        chk("R1 grant_n in reset", grant_n, 1'b1);
        chk("R1 bus_yield in reset", bus_yield, 1'b0);
        rst_n = 1'b1;
        step(3);
        chk("R1 grant_n after reset", grant_n, 1'b1);
        chk("R1 bus_yield after reset", bus_yield, 1'b0);

        // Scenario A: basic grant, acknowledge, release.
        req_n = 1'b0; step(2);
        chk("R2 no grant before sync", grant_n, 1'b1);
        step(1);
        chk("R2 grant after sync", grant_n, 1'b0);
        chk("R9 yield with grant", bus_yield, 1'b1);
        ack_n = 1'b0; req_n = 1'b1; step(4);
        chk("R5 grant held during delay", grant_n, 1'b0);
        step(1);
        chk("R5 grant negated", grant_n, 1'b1);
        chk("R9 yield while owned", bus_yield, 1'b1);
        step(5);
        chk("R9 yield while ack held", bus_yield, 1'b1);
        ack_n = 1'b1; step(2);
        chk("R9 yield before sync", bus_yield, 1'b1);
        step(1);
        chk("R9 yield released", bus_yield, 1'b0);
        to_idle();

        // Scenario B: lock holds off grant, then withdrawal.
        rmw_lock = 1'b1; req_n = 1'b0; step(6);
        chk("R3 no grant under lock", grant_n, 1'b1);
        chk("R3 no yield under lock", bus_yield, 1'b0);
        rmw_lock = 1'b0; step(1);
        chk("R3 grant after lock", grant_n, 1'b0);
        req_n = 1'b1; step(2);
        chk("R8 grant before withdraw", grant_n, 1'b0);
        step(1);
        chk("R8 grant withdrawn", grant_n, 1'b1);
        chk("R8 yield cleared", bus_yield, 1'b0);
        to_idle();

        // Scenario C: boundary gating.
        op_end = 1'b0; req_n = 1'b0; step(5);
        chk("R2 no grant mid transfer", grant_n, 1'b1);
        op_end = 1'b1; step(1);
        chk("R2 grant at boundary", grant_n, 1'b0);
        op_end = 1'b0; req_n = 1'b1; step(3);
        chk("R8 withdrawn after boundary", grant_n, 1'b1);
        to_idle();

        // Scenario D: halted acts as a boundary.
        halted = 1'b1; op_end = 1'b0; req_n = 1'b0; step(2);
        chk("R4 no grant before sync", grant_n, 1'b1);
        step(1);
        chk("R4 grant while halted", grant_n, 1'b0);
        to_idle();

        // Scenario E: re-grant with a pending request.
        req_n = 1'b0; step(3);
        chk("R2 grant for first master", grant_n, 1'b0);
        ack_n = 1'b0; step(4);
        chk("R5 held before negation", grant_n, 1'b0);
        step(1);
        chk("R5 negated after ack", grant_n, 1'b1);
        step(1);
        chk("R6 gap before re-grant", grant_n, 1'b1);
        step(1);
        chk("R6 re-grant issued", grant_n, 1'b0);
        step(6);
        chk("R7 held ack ignored", grant_n, 1'b0);
        ack_n = 1'b1; step(3);
        chk("R7 grant after ack release", grant_n, 1'b0);
        ack_n = 1'b0; req_n = 1'b1; step(4);
        chk("R7 held before new negation", grant_n, 1'b0);
        step(1);
        chk("R7 negated on new ack", grant_n, 1'b1);
        ack_n = 1'b1; step(3);
        chk("R9 yield cleared after re-grant", bus_yield, 1'b0);
        to_idle();

        // Random traffic with an acknowledging agent.
        rq0 = req_n; rq1 = req_n; rq2 = req_n;
        oe_c = op_end; hl_c = halted; lk_c = rmw_lock;
        yprev = bus_yield;
        phase = 0; dly = 0; hold = 0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (!yprev)
                chk("R2 random idle decision", grant_n, !exp_offer(rq2, oe_c, hl_c, lk_c));
            if (!grant_n)
                chk("R9 random grant implies yield", bus_yield, 1'b1);
            yprev = bus_yield;
            case (phase)
                0: begin
                    if (req_n) begin
                        if ($urandom % 4 == 0) req_n = 1'b0;
                    end else if (!grant_n) begin
                        dly = $urandom % 3; phase = 1;
                    end else if ($urandom % 16 == 0) begin
                        req_n = 1'b1;
                    end
                end
                1: begin
                    if (dly == 0) begin
                        ack_n = 1'b0;
                        if ($urandom % 4 != 0) req_n = 1'b1;
                        hold = 1 + $urandom % 8; phase = 2;
                    end else dly--;
                end
                default: begin
                    if (hold == 0) begin ack_n = 1'b1; phase = 0; end
                    else hold--;
                end
            endcase
            op_end   = ($urandom % 2 == 0);
            rmw_lock = ($urandom % 4 == 0);
            halted   = ($urandom % 8 == 0);
            rq2 = rq1; rq1 = rq0; rq0 = req_n;
            oe_c = op_end; hl_c = halted; lk_c = rmw_lock;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule